// File: doc/BRIEF.md
# One-Time Write-Protect Controller

This block sits beside the byte-level front end of a two-wire serial slave that serves a 256-byte nonvolatile array. It watches the decoded transaction events the front end reports (start, stop, a received device-address byte with its four-bit device type and direction bit, and each further received byte). From these it recognises a single complete byte-write transaction aimed at a reserved device type that selects a protect register rather than the array.

When such a transaction ends with a stop, a sticky lock flag is set. From then on every array write strobe whose address falls in the lower half (address bit 7 = 0) is suppressed. Writes to the upper half still reach the array. The reserved device type is never acknowledged again, so the register behaves as write-once. The byte-address and data values of the locking transaction carry no meaning. Only reset clears the flag, and reset stands in for the blank nonvolatile state.

Top module: `otp_wp_ctrl`

## Requirements
- R1: A device-address event with type 4'b0110 and direction bit 0 (write) is acknowledged on `wp_ack_o` in the same cycle while unlocked. So are the next two byte events of that transaction (byte address, then data), whatever their values.
- R2: `wp_locked_o` becomes 1 on the clock edge that samples a stop, and only when the stop follows a protect-write address event, exactly two byte events and no start. A stop after a missing data byte, or a start anywhere in the sequence, leaves the flag at 0.
- R3: While locked, `arr_we_o` is 0 whenever `arr_addr_i[7]` is 0, regardless of `arr_we_i`.
- R4: Once set, `wp_locked_o` stays 1 under any bus traffic until reset.
- R5: `arr_we_o` equals `arr_we_i` whenever `arr_addr_i[7]` is 1, and for every address while unlocked. A page write crossing from 0x7F to 0x80 while locked therefore passes only the upper bytes.
- R6: While locked, no device-address event or byte event raises `wp_ack_o`.
- R7: After reset, `wp_locked_o` is 0 and `wp_ack_o` is 0.
- R8: A read (direction bit 1) to type 4'b0110, and any event with another device type such as the array type 4'b1010, never raises `wp_ack_o`.
- R9: A third byte event in a protect-write transaction is not acknowledged and cancels the transaction, so a following stop leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start or repeated start seen (one-cycle pulse) |
| stop_i | input | 1 | Stop seen (one-cycle pulse) |
| dev_vld_i | input | 1 | Device-address byte received (one-cycle pulse) |
| dev_type_i | input | 4 | Device type field of that byte |
| dev_rw_i | input | 1 | Direction bit of that byte, 1 = read |
| byte_vld_i | input | 1 | Further byte received (one-cycle pulse) |
| arr_we_i | input | 1 | Array write strobe from the front end |
| arr_addr_i | input | 8 | Array address of that strobe |
| arr_we_o | output | 1 | Gated array write strobe |
| wp_ack_o | output | 1 | Acknowledge request for the current event |
| wp_locked_o | output | 1 | Protect flag status |

## Verification
The acknowledge and the gated write strobe are combinational. Each is due in the cycle its event is presented, so the bench drives events just after a falling edge and samples one time unit later, before the next rising edge. The lock flag is registered and is due on the rising edge that samples the stop, so it is read at the following falling edge. After reset is released, two further edges pass through the synchroniser before the bench applies any event.

// File: rtl/otp_wp_pkg.sv
package otp_wp_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_DEV  = 2'd1,
    SQ_ADDR = 2'd2,
    SQ_DATA = 2'd3
  } seq_t;

  localparam logic [3:0] WP_TYPE_CODE  = 4'b0110;
  localparam logic [3:0] ARR_TYPE_CODE = 4'b1010;
endpackage

// File: rtl/otp_wp_seq.sv
module otp_wp_seq
  import otp_wp_pkg::*;
#(
  parameter int unsigned TYPE_W = 4,
  parameter logic [TYPE_W-1:0] PROT_CODE = WP_TYPE_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              dev_vld_i,
  input  logic [TYPE_W-1:0] dev_type_i,
  input  logic              dev_rw_i,
  input  logic              byte_vld_i,
  output logic              ack_o,
  output logic              commit_o
);
  seq_t st_q, st_d;
  logic hit;

  assign hit = dev_vld_i && (dev_type_i == PROT_CODE) && !dev_rw_i && !locked;

  always_comb begin
    st_d     = st_q;
    ack_o    = 1'b0;
    commit_o = 1'b0;
    if (start_i) begin
      st_d = SQ_IDLE;
    end else if (stop_i) begin
      commit_o = (st_q == SQ_DATA);
      st_d     = SQ_IDLE;
    end else if (dev_vld_i) begin
      ack_o = hit;
      st_d  = hit ? SQ_DEV : SQ_IDLE;
    end else if (byte_vld_i) begin
      unique case (st_q)
        SQ_DEV:  begin ack_o = 1'b1; st_d = SQ_ADDR; end
        SQ_ADDR: begin ack_o = 1'b1; st_d = SQ_DATA; end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/otp_wp_flag.sv
module otp_wp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic flag_o
);
  logic flag_d;

  always_comb flag_d = flag_o | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= flag_d;
  end
endmodule

// File: rtl/otp_wp_gate.sv
module otp_wp_gate #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              locked,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              we_o
);
  localparam int unsigned MSB = ADDR_W - 1;
  logic in_prot;

  assign in_prot = !addr_i[MSB];
  assign we_o    = we_i && !(locked && in_prot);
endmodule

// File: rtl/otp_wp_ctrl.sv
module otp_wp_ctrl
  import otp_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned TYPE_W = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [TYPE_W-1:0] PROT_CODE = WP_TYPE_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              dev_vld_i,
  input  logic [TYPE_W-1:0] dev_type_i,
  input  logic              dev_rw_i,
  input  logic              byte_vld_i,
  input  logic              arr_we_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  output logic              arr_we_o,
  output logic              wp_ack_o,
  output logic              wp_locked_o
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  otp_wp_seq #(.TYPE_W(TYPE_W), .PROT_CODE(PROT_CODE)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .locked(wp_locked_o),
    .start_i(start_i), .stop_i(stop_i), .dev_vld_i(dev_vld_i),
    .dev_type_i(dev_type_i), .dev_rw_i(dev_rw_i), .byte_vld_i(byte_vld_i),
    .ack_o(wp_ack_o), .commit_o(commit)
  );

  otp_wp_flag u_flag (
    .clk(clk), .rst_n(rst_int_n), .set_i(commit), .flag_o(wp_locked_o)
  );

  otp_wp_gate #(.ADDR_W(ADDR_W)) u_gate (
    .locked(wp_locked_o), .we_i(arr_we_i), .addr_i(arr_addr_i), .we_o(arr_we_o)
  );
endmodule

module otp_wp_ctrl_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned TYPE_W = 4
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              stop_i,
  input logic              start_i,
  input logic              dev_vld_i,
  input logic              dev_rw_i,
  input logic              arr_we_i,
  input logic [ADDR_W-1:0] arr_addr_i,
  input logic              arr_we_o,
  input logic              wp_ack_o,
  input logic              wp_locked_o
);
  // R2: flag rises only on an edge that sampled a stop without a start
  a_r2_set_on_stop: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(wp_locked_o) |-> $past(stop_i) && !$past(start_i));
  // R4: flag is sticky
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    wp_locked_o |=> wp_locked_o);
  // R3: lower half blocked while locked
  a_r3_lower_blocked: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wp_locked_o && !arr_addr_i[ADDR_W-1]) |-> !arr_we_o);
  // R5: upper half always passes
  a_r5_upper_pass: assert property (@(posedge clk) disable iff (!rst_int_n)
    arr_addr_i[ADDR_W-1] |-> (arr_we_o == arr_we_i));
  // R6: no acknowledge once locked
  a_r6_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    wp_locked_o |-> !wp_ack_o);
  // R8: reads are never acknowledged
  a_r8_read_nack: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dev_vld_i && dev_rw_i) |-> !wp_ack_o);
endmodule

bind otp_wp_ctrl otp_wp_ctrl_chk #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .stop_i(stop_i), .start_i(start_i),
  .dev_vld_i(dev_vld_i), .dev_rw_i(dev_rw_i), .arr_we_i(arr_we_i),
  .arr_addr_i(arr_addr_i), .arr_we_o(arr_we_o), .wp_ack_o(wp_ack_o),
  .wp_locked_o(wp_locked_o)
);

// File: tb/sim_otp_wp_ctrl.sv
`timescale 1ns/1ps
module sim_otp_wp_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, stop_i, dev_vld_i, dev_rw_i, byte_vld_i, arr_we_i;
  logic [3:0] dev_type_i;
  logic [7:0] arr_addr_i;
  logic       arr_we_o, wp_ack_o, wp_locked_o;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  otp_wp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .dev_vld_i(dev_vld_i), .dev_type_i(dev_type_i), .dev_rw_i(dev_rw_i),
    .byte_vld_i(byte_vld_i), .arr_we_i(arr_we_i), .arr_addr_i(arr_addr_i),
    .arr_we_o(arr_we_o), .wp_ack_o(wp_ack_o), .wp_locked_o(wp_locked_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    start_i = 0; stop_i = 0; dev_vld_i = 0; dev_rw_i = 0;
    byte_vld_i = 0; arr_we_i = 0; dev_type_i = 4'h0; arr_addr_i = 8'h00;
  endtask

  // Drive one event just after a falling edge; return the same-cycle ack.
  task automatic ev_start();
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
  endtask
  task automatic ev_stop();
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
  endtask
  task automatic ev_dev(input logic [3:0] t, input logic rw, output logic ack);
    @(negedge clk); dev_vld_i = 1; dev_type_i = t; dev_rw_i = rw;
    #1 ack = wp_ack_o;
    @(negedge clk); dev_vld_i = 0;
  endtask
  task automatic ev_byte(output logic ack);
    @(negedge clk); byte_vld_i = 1;
    #1 ack = wp_ack_o;
    @(negedge clk); byte_vld_i = 0;
  endtask
  task automatic arr_probe(input logic [7:0] a, input logic we, output logic o);
    @(negedge clk); arr_we_i = we; arr_addr_i = a;
    #1 o = arr_we_o;
    @(negedge clk); arr_we_i = 0;
  endtask

  task automatic do_reset();
    idle_bus();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic o;
    check("R7 locked after reset", wp_locked_o, 1'b0);
    check("R7 ack after reset", wp_ack_o, 1'b0);
    arr_probe(8'h10, 1'b1, o); check("R5 low write unlocked", o, 1'b1);
    arr_probe(8'h7F, 1'b1, o); check("R5 0x7F write unlocked", o, 1'b1);
  endtask

  task automatic t_other_codes();
    logic a;
    ev_start(); ev_dev(4'b0110, 1'b1, a); check("R8 read protect code", a, 1'b0);
    ev_stop();
    ev_start(); ev_dev(4'b1010, 1'b0, a); check("R8 array code", a, 1'b0);
    ev_byte(a); check("R8 array byte", a, 1'b0);
    ev_byte(a); check("R8 array data", a, 1'b0);
    ev_stop(); check("R2 array write no lock", wp_locked_o, 1'b0);
  endtask

  task automatic t_truncated();
    logic a;
    ev_start(); ev_dev(4'b0110, 1'b0, a); check("R1 dev ack", a, 1'b1);
    ev_byte(a); check("R1 addr ack", a, 1'b1);
    ev_stop(); check("R2 missing data no lock", wp_locked_o, 1'b0);
    ev_start(); ev_dev(4'b0110, 1'b0, a);
    ev_byte(a); ev_byte(a); check("R1 data ack", a, 1'b1);
    ev_start(); ev_stop();
    check("R2 restart no lock", wp_locked_o, 1'b0);
  endtask

  task automatic t_extra_byte();
    logic a;
    ev_start(); ev_dev(4'b0110, 1'b0, a);
    ev_byte(a); ev_byte(a);
    ev_byte(a); check("R9 third byte nack", a, 1'b0);
    ev_stop(); check("R9 no lock after extra", wp_locked_o, 1'b0);
  endtask

  task automatic t_lock();
    logic a;
    ev_start(); ev_dev(4'b0110, 1'b0, a); check("R1 dev ack lock seq", a, 1'b1);
    ev_byte(a); ev_byte(a);
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    check("R2 locked after stop", wp_locked_o, 1'b1);
  endtask

  task automatic t_after_lock();
    logic a;
    ev_start(); ev_dev(4'b0110, 1'b0, a); check("R6 dev nack", a, 1'b0);
    ev_byte(a); check("R6 byte nack", a, 1'b0);
    ev_byte(a); ev_stop();
    check("R4 still locked", wp_locked_o, 1'b1);
    ev_start(); ev_dev(4'b1010, 1'b0, a); ev_byte(a); ev_stop();
    check("R4 locked after array traffic", wp_locked_o, 1'b1);
  endtask

  task automatic t_gate();
    logic o;
    arr_probe(8'h00, 1'b1, o); check("R3 0x00 blocked", o, 1'b0);
    arr_probe(8'h7E, 1'b1, o); check("R3 0x7E blocked", o, 1'b0);
    arr_probe(8'h7F, 1'b1, o); check("R3 0x7F blocked", o, 1'b0);
    arr_probe(8'h80, 1'b1, o); check("R5 0x80 passes", o, 1'b1);
    arr_probe(8'h81, 1'b1, o); check("R5 0x81 passes", o, 1'b1);
    arr_probe(8'hFF, 1'b1, o); check("R5 0xFF passes", o, 1'b1);
    arr_probe(8'hC0, 1'b0, o); check("R5 idle strobe", o, 1'b0);
  endtask

  initial begin
    idle_bus();
    rst_n = 0;
    do_reset();
    t_reset_state();
    t_other_codes();
    t_truncated();
    t_extra_byte();
    t_lock();
    t_after_lock();
    t_gate();
    do_reset();
    check("R7 reset clears lock", wp_locked_o, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule